// File: doc/BRIEF.md
# Firmware Memory Cycle Target on a 4-bit Multiplexed Host Bus

This block is the slave side of firmware memory read and write cycles on a narrow host bus. The bus has a 4-bit multiplexed data path, an active-low frame strobe and a clock. The target watches the frame strobe for a start nibble. It checks a device-select nibble against four strap inputs. It then gathers a seven-nibble address and a size nibble. For a write, it takes the data bytes from the host. For a read, it waits out the host's turnaround, signals ready and returns the data bytes. In both cases it ends with a turnaround that hands the bus back to the host.

The byte array sits behind the decoder as a small synchronous memory with a single port. A read burst or write burst walks through the array one byte at a time. The address stays inside a window of the burst size, aligned to that size. Any cycle that the target does not accept is dropped without notice: the target never drives the bus for it and never changes the array. The bus pins appear as an input nibble, an output nibble and an output enable, so the pad ring can build the tri-state driver.

Top module: `lpc_fw_target`

## Requirements
- R1: While reset is held and after it is released, the target does not drive the bus (`lad_oe` = 0).
- R2: A read cycle has these fields in order: start nibble 1101b with `frame_n` low, a select nibble equal to `id_strap`, seven address nibbles, a size nibble and two host turnaround clocks. In the clock after the two turnaround clocks, the target drives 0000b (ready). It then drives the data, then 1111b for one clock, and then releases the bus.
- R3: A write cycle has these fields in order: start nibble 1110b, select, address, size, the data bytes, two host turnaround clocks. The target stores each byte, then drives 0000b for one clock and 1111b for one clock, and then releases the bus.
- R4: If the select nibble differs from `id_strap`, the target ignores the cycle. It does not drive the bus and does not change the array.
- R5: The size nibble sets the burst length of a read: 0000b is 1 byte, 0001b is 2, 0010b is 4, 0100b is 16 and 0111b is 128.
- R6: Writes accept only size codes 0000b, 0001b and 0010b. A write cycle with any other size code is ignored: no drive and no array change.
- R7: A read cycle with a size code outside the five legal ones is ignored, with no drive.
- R8: The address is sent most significant nibble first. Only its low `MEM_AW` bits select the array byte, so the upper bits have no effect.
- R9: Each byte after the first goes to the next address, and the address wraps within the window of the burst size, aligned to that size. For example, a 4-byte burst at 0x12 uses 0x12, 0x13, 0x10, 0x11.
- R10: `frame_n` low at any clock ends the current cycle. If the nibble seen in that clock is a legal start nibble, a new cycle begins. Otherwise the target returns to idle and drops its drive in the next clock.
- R11: A start nibble other than 1101b or 1110b is ignored, with no drive.
- R12: Data bytes go low nibble first, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all fields are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Active-low frame strobe marking a start nibble |
| lad_in | input | 4 | Nibble received from the bus |
| lad_out | output | 4 | Nibble the target drives onto the bus |
| lad_oe | output | 1 | High while the target drives the bus |
| id_strap | input | 4 | Strapped device-select value |

## Verification
The bench builds the block with `MEM_AW` = 8, which gives a 256-byte array. With this size the bench can fill the whole array through 4-byte writes and later confirm that rejected cycles left every location unchanged. The small array also puts the 128-byte window wrap, and the aliasing of the upper address bits onto the same bytes, within a few thousand clocks. The strap is held at 0101b, so a select of 1010b exercises the mismatch path.

// File: rtl/lpc_fw_pkg.sv
package lpc_fw_pkg;
  localparam logic [3:0] START_RD  = 4'b1101;
  localparam logic [3:0] START_WR  = 4'b1110;
  localparam int ADDR_NIBS = 7;
  localparam int ADDR_W    = 4 * ADDR_NIBS;
  localparam int MAX_BYTES = 128;
  localparam int CNT_W     = $clog2(2 * MAX_BYTES);

  typedef enum logic [3:0] {
    ST_IDLE, ST_IDSEL, ST_ADDR, ST_SIZE, ST_WDATA,
    ST_HTAR0, ST_HTAR1, ST_SYNC, ST_RDATA, ST_TTAR0, ST_TTAR1
  } fw_state_e;

  // log2 of the burst length for a size code
  function automatic logic [2:0] size_log2(input logic [3:0] code);
    case (code)
      4'b0001: return 3'd1;
      4'b0010: return 3'd2;
      4'b0100: return 3'd4;
      4'b0111: return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic size_legal(input logic [3:0] code, input logic rd);
    case (code)
      4'b0000, 4'b0001, 4'b0010: return 1'b1;
      4'b0100, 4'b0111:          return rd;
      default:                   return 1'b0;
    endcase
  endfunction

  // next address, wrapping inside the aligned window of 2**lg bytes
  function automatic logic [ADDR_W-1:0] window_step(input logic [ADDR_W-1:0] a,
                                                     input logic [2:0] lg);
    logic [ADDR_W-1:0] m;
    m = ({{(ADDR_W-1){1'b0}}, 1'b1} << lg) - 1'b1;
    return (a & ~m) | ((a + 1'b1) & m);
  endfunction

  // nibble counter load: two nibbles per byte, counted down to zero
  function automatic logic [CNT_W-1:0] nib_load(input logic [2:0] lg);
    int n;
    n = (2 << lg) - 1;
    return n[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/lpc_fw_sram.sv
module lpc_fw_sram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= cells[addr];
  end
endmodule

// File: rtl/lpc_fw_decode.sv
module lpc_fw_decode
  import lpc_fw_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  input  logic [3:0]        id_strap,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam logic [CNT_W-1:0] ADDR_LOAD = CNT_W'(ADDR_NIBS - 1);

  fw_state_e          st;
  logic               is_rd;
  logic [ADDR_W-1:0]  addr;
  logic [2:0]         lg;
  logic [CNT_W-1:0]   cnt;
  logic [3:0]         lo_nib;

  // named events
  logic start_hit, id_miss, size_bad, nib_hi, wr_byte, rd_step, addr_step, tar_drive;
  assign start_hit = !frame_n && (lad_in == START_RD || lad_in == START_WR);
  assign id_miss   = (st == ST_IDSEL) && (lad_in != id_strap);
  assign size_bad  = (st == ST_SIZE) && !size_legal(lad_in, is_rd);
  assign nib_hi    = ~cnt[0];
  assign wr_byte   = (st == ST_WDATA) && nib_hi;
  assign rd_step   = (st == ST_RDATA) && !nib_hi;
  assign addr_step = wr_byte || rd_step;
  assign tar_drive = (st == ST_TTAR0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      is_rd  <= 1'b0;
      addr   <= '0;
      lg     <= '0;
      cnt    <= '0;
      lo_nib <= '0;
    end else if (!frame_n) begin
      st    <= start_hit ? ST_IDSEL : ST_IDLE;
      is_rd <= (lad_in == START_RD);
    end else begin
      case (st)
        ST_IDSEL: begin
          st  <= id_miss ? ST_IDLE : ST_ADDR;
          cnt <= ADDR_LOAD;
        end
        ST_ADDR: begin
          addr <= {addr[ADDR_W-5:0], lad_in};
          cnt  <= cnt - 1'b1;
          if (cnt == '0) st <= ST_SIZE;
        end
        ST_SIZE: begin
          if (size_bad) st <= ST_IDLE;
          else begin
            lg  <= size_log2(lad_in);
            cnt <= nib_load(size_log2(lad_in));
            st  <= is_rd ? ST_HTAR0 : ST_WDATA;
          end
        end
        ST_WDATA: begin
          if (!nib_hi) lo_nib <= lad_in;
          if (addr_step) addr <= window_step(addr, lg);
          cnt <= cnt - 1'b1;
          if (cnt == '0) st <= ST_HTAR0;
        end
        ST_HTAR0: st <= ST_HTAR1;
        ST_HTAR1: st <= ST_SYNC;
        ST_SYNC:  st <= is_rd ? ST_RDATA : ST_TTAR0;
        ST_RDATA: begin
          if (addr_step) addr <= window_step(addr, lg);
          cnt <= cnt - 1'b1;
          if (cnt == '0) st <= ST_TTAR0;
        end
        ST_TTAR0: st <= ST_TTAR1;
        ST_TTAR1: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr  = addr[MEM_AW-1:0];
  assign mem_we    = wr_byte && frame_n;
  assign mem_wdata = {lad_in, lo_nib};

  always_comb begin
    lad_oe  = 1'b0;
    lad_out = 4'h0;
    case (st)
      ST_SYNC:  lad_oe = 1'b1;
      ST_RDATA: begin
        lad_oe  = 1'b1;
        lad_out = nib_hi ? mem_rdata[7:4] : mem_rdata[3:0];
      end
      ST_TTAR0: begin
        lad_oe  = 1'b1;
        lad_out = 4'hF;
      end
      default: ;
    endcase
  end

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && lad_in != START_RD && lad_in != START_WR) |=> !lad_oe);
  // R2
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> (lad_out == 4'h0));
  // R4
  id_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_miss && frame_n) |=> (!lad_oe && !mem_we));
  // R6
  size_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_bad && frame_n) |=> (!lad_oe && !mem_we));
  // R2
  tar_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tar_drive && frame_n) |=> !lad_oe);
  // R9
  window_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_step && frame_n) |=> ((addr >> lg) == ($past(addr) >> lg)));
endmodule

// File: rtl/lpc_fw_target.sv
module lpc_fw_target #(
  parameter int MEM_AW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [3:0] lad_in,
  output logic [3:0] lad_out,
  output logic       lad_oe,
  input  logic [3:0] id_strap
);
  logic [MEM_AW-1:0] m_addr;
  logic              m_we;
  logic [7:0]        m_wdata;
  logic [7:0]        m_rdata;

  lpc_fw_decode #(.MEM_AW(MEM_AW)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .lad_in    (lad_in),
    .id_strap  (id_strap),
    .lad_out   (lad_out),
    .lad_oe    (lad_oe),
    .mem_addr  (m_addr),
    .mem_we    (m_we),
    .mem_wdata (m_wdata),
    .mem_rdata (m_rdata)
  );

  lpc_fw_sram #(.AW(MEM_AW)) u_array (
    .clk   (clk),
    .addr  (m_addr),
    .we    (m_we),
    .wdata (m_wdata),
    .rdata (m_rdata)
  );
endmodule

// File: tb/lpc_fw_target_tb.sv
module lpc_fw_target_tb;
  localparam logic [3:0] MY_ID = 4'h5;
  localparam logic [3:0] RD = 4'b1101;
  localparam logic [3:0] WR = 4'b1110;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic       lad_oe;
  logic [3:0] id_strap = MY_ID;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf [128];

  always #4 clk = ~clk;

  lpc_fw_target #(.MEM_AW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .id_strap(id_strap)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int widx(input int a, input int n, input int i);
    int off;
    off = a % n;
    return (a - off) + ((off + i) % n);
  endfunction

  task automatic drive(input logic f, input logic [3:0] v);
    @(negedge clk);
    frame_n = f;
    lad_in  = v;
  endtask

  task automatic head(input logic [3:0] s, input logic [3:0] id,
                      input logic [27:0] a, input logic [3:0] sz);
    drive(1'b0, s);
    drive(1'b1, id);
    for (int i = 6; i >= 0; i--) drive(1'b1, a[4*i +: 4]);
    drive(1'b1, sz);
  endtask

  // R3 R12: full write cycle, then model update
  task automatic do_write(input logic [27:0] a, input logic [3:0] sz, input int n);
    head(WR, MY_ID, a, sz);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, wbuf[i][3:0]);
      drive(1'b1, wbuf[i][7:4]);
    end
    drive(1'b1, 4'hF);
    drive(1'b1, 4'hF);
    @(negedge clk);
    check(lad_oe && lad_out == 4'h0, "R3 write ready nibble", {lad_oe, lad_out}, 5'h10);
    @(negedge clk);
    check(lad_oe && lad_out == 4'hF, "R3 write turnaround", {lad_oe, lad_out}, 5'h1F);
    @(negedge clk);
    check(!lad_oe, "R3 write release", lad_oe, 0);
    for (int i = 0; i < n; i++) model[widx(int'(a[7:0]), n, i)] = wbuf[i];
  endtask

  // R2 R5 R9 R12: full read cycle compared with the model
  task automatic do_read(input logic [27:0] a, input logic [3:0] sz, input int n,
                         input string req);
    logic [7:0] got;
    int bad;
    int exp;
    head(RD, MY_ID, a, sz);
    drive(1'b1, 4'hF);
    drive(1'b1, 4'hF);
    @(negedge clk);
    check(lad_oe && lad_out == 4'h0, "R2 read ready nibble", {lad_oe, lad_out}, 5'h10);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got[3:0] = lad_out;
      if (!lad_oe) bad++;
      @(negedge clk);
      got[7:4] = lad_out;
      if (!lad_oe) bad++;
      exp = int'(model[widx(int'(a[7:0]), n, i)]);
      check(int'(got) == exp, req, got, exp);
    end
    check(bad == 0, "R2 drive held during data", bad, 0);
    @(negedge clk);
    check(lad_oe && lad_out == 4'hF, "R2 read turnaround", {lad_oe, lad_out}, 5'h1F);
    @(negedge clk);
    check(!lad_oe, "R2 read release", lad_oe, 0);
  endtask

  // idle clocks, counting any drive seen
  task automatic quiet(input int clocks, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < clocks; i++) begin
      drive(1'b1, 4'hF);
      if (lad_oe) seen++;
    end
    @(negedge clk);
    if (lad_oe) seen++;
    check(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!lad_oe, "R1 no drive in reset", lad_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!lad_oe, "R1 no drive after reset", lad_oe, 0);
  endtask

  task automatic t_fill;
    for (int b = 0; b < 256; b += 4) begin
      for (int i = 0; i < 4; i++) wbuf[i] = 8'((b + i) * 37 + 11);
      do_write(28'(b), 4'b0010, 4);
    end
  endtask

  task automatic t_read_sizes;
    do_read(28'h0000005, 4'b0000, 1, "R5 one byte");
    do_read(28'h0000021, 4'b0001, 2, "R5 two bytes");
    do_read(28'h0000046, 4'b0010, 4, "R5 four bytes wrap");
    do_read(28'h0000035, 4'b0100, 16, "R9 sixteen bytes wrap");
    do_read(28'h0000083, 4'b0111, 128, "R5 128 bytes wrap");
  endtask

  task automatic t_write_wrap;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    do_write(28'h0000012, 4'b0010, 4);
    do_read(28'h0000010, 4'b0010, 4, "R9 write wrap order");
    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
    do_write(28'h0000041, 4'b0001, 2);
    do_read(28'h0000040, 4'b0001, 2, "R12 two byte write");
    wbuf[0] = 8'h77;
    do_write(28'h0000009, 4'b0000, 1);
    do_read(28'h0000009, 4'b0000, 1, "R3 one byte write");
  endtask

  task automatic t_high_addr;
    wbuf[0] = 8'h3C;
    do_write(28'hABCDE60, 4'b0000, 1);
    do_read(28'h0000060, 4'b0000, 1, "R8 upper bits dropped");
    do_read(28'h7777760, 4'b0000, 1, "R8 upper bits dropped on read");
  endtask

  task automatic t_id_miss;
    head(WR, 4'hA, 28'h0000070, 4'b0000);
    drive(1'b1, 4'hE); drive(1'b1, 4'hE);
    quiet(6, "R4 write with wrong select not driven");
    head(RD, 4'hA, 28'h0000070, 4'b0000);
    quiet(8, "R4 read with wrong select not driven");
    do_read(28'h0000070, 4'b0000, 1, "R4 array unchanged");
  endtask

  task automatic t_bad_size;
    head(WR, MY_ID, 28'h0000090, 4'b0100);
    for (int i = 0; i < 32; i++) drive(1'b1, 4'h0);
    quiet(4, "R6 sixteen byte write not driven");
    head(WR, MY_ID, 28'h0000094, 4'b0111);
    for (int i = 0; i < 8; i++) drive(1'b1, 4'h0);
    quiet(4, "R6 128 byte write not driven");
    do_read(28'h0000090, 4'b0100, 16, "R6 array unchanged");
    head(RD, MY_ID, 28'h0000010, 4'b0011);
    quiet(8, "R7 illegal read size not driven");
  endtask

  task automatic t_other_start;
    head(4'b0000, MY_ID, 28'h0000010, 4'b0000);
    quiet(8, "R11 other start nibble not driven");
  endtask

  task automatic t_abort;
    // abort during address, then a new write
    drive(1'b0, RD); drive(1'b1, MY_ID); drive(1'b1, 4'h0); drive(1'b1, 4'h0);
    wbuf[0] = 8'hE7;
    do_write(28'h00000A0, 4'b0000, 1);
    do_read(28'h00000A0, 4'b0000, 1, "R10 restart after abort");
    // abort during read data with a non-start nibble
    head(RD, MY_ID, 28'h00000B0, 4'b0100);
    drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    @(negedge clk); @(negedge clk); @(negedge clk);
    check(lad_oe, "R10 driving before abort", lad_oe, 1);
    frame_n = 1'b0;
    lad_in  = 4'h0;
    @(negedge clk);
    frame_n = 1'b1;
    lad_in  = 4'hF;
    check(!lad_oe, "R10 abort drops drive", lad_oe, 0);
    // abort during read data with a read start
    head(RD, MY_ID, 28'h00000C0, 4'b0100);
    drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    @(negedge clk); @(negedge clk);
    do_read(28'h00000C4, 4'b0001, 2, "R10 read restart mid data");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_read_sizes();
    t_write_wrap();
    t_high_addr();
    t_id_miss();
    t_bad_size();
    t_other_start();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule